// File: doc/BRIEF.md
# Dual-Source Divided Clock Output

This block drives one gated, divided clock output from one of two sources: a slow 32768 Hz reference and a fast source of about 4 MHz. An 8-bit configuration byte, written through a plain write strobe, chooses the source, an optional pre-divide ratio for the fast source, a power-of-two post-divide and an output enable. A system may place several copies side by side. This block is a single output.

Both sources reach the block as single-cycle strobes on one system clock. A strobe marks each edge of a source clock, so there are two strobes per source period. The output is a registered level. It toggles after every D strobes of the selected source, where D is the pre-divide ratio times 2^n. The output therefore runs at the source frequency divided by D, with equal high and low phases. A written configuration stays pending until the current output period closes, which is the high-to-low transition of the output. While the output is idle it takes effect at once. A period that is in progress is never cut short or stretched.

Top module: `cko_divider`

## Requirements
- R1: During and after reset the output is low and the stored configuration byte is zero, so the output stays disabled and produces no transitions until a byte with bit 0 set is written.
- R2: Bit 0 of the configuration byte is the output enable. While the active enable is 0 the output is held low and makes no transitions, whatever the other fields hold.
- R3: Bit 4 selects the source. A value of 0 counts slow-source strobes (`slow_tick`) and a value of 1 counts fast-source strobes (`fast_tick`). Strobes of the other source have no effect.
- R4: Bits 7:5 are a pre-divide code for the fast source. Codes 0 to 6 divide by 2^code (1, 2, 4, 8, 16, 32, 64) and code 7 divides by 122.
- R5: With the slow source selected, the pre-divide code is ignored and the ratio is 1.
- R6: Bits 3:1 are a post-divide exponent n, giving a further divide by 2^n for n from 0 to 7.
- R7: With the output running, each high phase and each low phase lasts exactly D strobes of the active source. D is the pre-divide ratio (when it applies) times 2^n, from 1 up to 15616. This gives 50% duty at every ratio, including 122.
- R8: A configuration write made while the output runs changes nothing until the next high-to-low output transition. The high phase in progress completes with the old settings, and the following phases use the new ones.
- R9: Clearing the enable while running lets the current period finish. The output then falls on schedule and stays low. Setting the enable from idle starts the output from the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Strobe per edge of the 32768 Hz source |
| fast_tick | input | 1 | Strobe per edge of the fast source |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: [7:5] pre code, [4] source, [3:1] exponent, [0] enable |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
The bench counts strobes of each source between output transitions. This catches a pre-divider that is applied to the slow source, and a code 7 that divides by 128 instead of 122. Each new setting is written just after a rising edge. A design that applied changes at once would give a high phase of the new length, where the bench expects the old length. Source switches and the shortest ratio (a toggle on every strobe) are exercised, since these are where an off-by-one counter or a misplaced load would show. Disabling mid-period must still give a full final high phase followed by silence. A gate that acted at once would cut that phase short.

// File: rtl/cko_pkg.sv
package cko_pkg;
  localparam int CFG_W      = 8;
  localparam int PRE_CODE_W = 3;
  localparam int EXP_W      = 3;
  localparam int PRE_TOP    = 122;
  localparam int PRE_CNT_W  = $clog2(PRE_TOP);
  localparam int POST_CNT_W = (1 << EXP_W) - 1;

  typedef struct packed {
    logic [PRE_CODE_W-1:0] pre_code;
    logic                  fast_sel;
    logic [EXP_W-1:0]      post_exp;
    logic                  out_en;
  } cko_cfg_t;

  // Ratio per pre-divide code: powers of two, except the top code.
  function automatic logic [PRE_CNT_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
    if (code == '1) return PRE_CNT_W'(PRE_TOP);
    return PRE_CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/cko_cfg_bank.sv
module cko_cfg_bank
  import cko_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             boundary,
  output cko_cfg_t         act_cfg
);
  cko_cfg_t stored;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored  <= '0;
      act_cfg <= '0;
    end else begin
      if (wr_en) stored <= cko_cfg_t'(wr_data);
      if (boundary) act_cfg <= wr_en ? cko_cfg_t'(wr_data) : stored;
    end
  end

  // R8: active settings move only on a period boundary
  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> $stable(act_cfg));
endmodule

// File: rtl/cko_prediv.sv
module cko_prediv
  import cko_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [PRE_CODE_W-1:0] code,
  input  logic                  bypass,
  input  logic                  clr,
  output logic                  pulse
);
  logic [PRE_CNT_W-1:0] cnt;
  logic [PRE_CNT_W-1:0] ratio;
  logic                 last;

  always_comb begin
    ratio = pre_ratio(code);
    last  = (cnt == ratio - PRE_CNT_W'(1));
    pulse = tick && (bypass || last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)      cnt <= '0;
    else if (tick && !bypass) cnt <= last ? '0 : cnt + PRE_CNT_W'(1);
  end

  // R4: count stays inside the selected ratio
  assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);
  // R5: the slow source never advances the pre-divider
  assert_pre_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (cnt == '0));
endmodule

// File: rtl/cko_postdiv.sv
module cko_postdiv
  import cko_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [EXP_W-1:0] post_exp,
  input  logic             en,
  output logic             out_q,
  output logic             period_end
);
  logic [POST_CNT_W-1:0] cnt;
  logic [POST_CNT_W-1:0] limit;
  logic                  hit;

  always_comb begin
    limit      = (POST_CNT_W'(1) << post_exp) - POST_CNT_W'(1);
    hit        = step && (cnt == limit);
    period_end = hit && out_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (hit) begin
      cnt   <= '0;
      out_q <= !out_q;
    end else if (step) begin
      cnt   <= cnt + POST_CNT_W'(1);
    end
  end

  // R2: a disabled gate holds the output low
  assert_gate_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !out_q);
  // R6: post count bounded by 2^n - 1
  assert_post_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/cko_divider.sv
module cko_divider
  import cko_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             clk_out
);
  cko_cfg_t act_cfg;
  logic     src_tick;
  logic     pre_pulse;
  logic     period_end;
  logic     boundary;

  // Idle output counts as a boundary so an enable from rest loads at once.
  assign boundary = period_end || !act_cfg.out_en;
  assign src_tick = act_cfg.fast_sel ? fast_tick : slow_tick;

  cko_cfg_bank u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .boundary (boundary),
    .act_cfg  (act_cfg)
  );

  cko_prediv u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (src_tick),
    .code   (act_cfg.pre_code),
    .bypass (!act_cfg.fast_sel),
    .clr    (boundary),
    .pulse  (pre_pulse)
  );

  cko_postdiv u_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (pre_pulse),
    .post_exp   (act_cfg.post_exp),
    .en         (act_cfg.out_en),
    .out_q      (clk_out),
    .period_end (period_end)
  );

  // R9: the gate opens or closes only with the output low
  assert_gate_change_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg.out_en) |-> !clk_out);
  // R2: a rising output edge requires an active enable
  assert_rise_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> act_cfg.out_en);
  // R3: output moves only after a strobe of the active source
  assert_move_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_out) && $past(act_cfg.out_en)) |->
      ($past(act_cfg.fast_sel) ? $past(fast_tick) : $past(slow_tick)));
endmodule

// File: tb/sim_cko_divider.sv
module sim_cko_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       clk_out;

  always #10 clk = !clk;

  cko_divider u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clk_out(clk_out)
  );

  // Stimulus table: configuration byte and expected phase length in strobes
  localparam int NV = 8;
  localparam logic [7:0] VEC_CFG [NV] = '{8'h01, 8'hA7, 8'h11, 8'h35, 8'hF1, 8'hD3, 8'hFF, 8'h0F};
  localparam int         VEC_HALF[NV] = '{1, 8, 1, 8, 122, 128, 15616, 128};

  int n_chk = 0, n_bad = 0;
  int cyc = 0, edges = 0, seen = 0;
  int cnt_s = 0, cnt_f = 0;
  logic last_out = 1'b0;
  int hs [1024];
  int hf [1024];

  // Monitor and strobe source, all at the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (clk_out !== last_out) begin
      hs[edges % 1024] = cnt_s;
      hf[edges % 1024] = cnt_f;
      edges++;
      cnt_s = 0;
      cnt_f = 0;
      last_out = clk_out;
    end
    slow_tick = (cyc % 4 == 0);
    fast_tick = (cyc % 7 != 0);
    if (slow_tick) cnt_s++;
    if (fast_tick) cnt_f++;
    if (cyc == 195000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 195000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Wait for the next output transition; return the strobe count of a source
  task automatic next_edge(input logic fast, output int half);
    int tmo = 0;
    while (edges <= seen) begin
      @(negedge clk); #1;
      tmo++;
      if (tmo > 40000) begin
        n_chk++; n_bad++;
        $display("FAIL timeout: no output edge, actual waited %0d expected < 40000", tmo);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
    half = fast ? hf[seen % 1024] : hs[seen % 1024];
    seen++;
  endtask

  initial begin
    int h;
    int e0;
    rst_n = 1'b0;
    cyc_wait(5);
    chk("R1 output low in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    e0 = edges;
    cyc_wait(60);
    chk("R1 no edges after reset", edges - e0, 0);
    seen = edges;

    // R2: every field set except the enable -> still silent and low
    write_cfg(8'hFE);
    e0 = edges;
    cyc_wait(300);
    chk("R2 disabled output edges", edges - e0, 0);
    chk("R2 disabled output level", int'(clk_out), 0);
    seen = edges;

    // Start from idle with the first vector (R9 start from low)
    write_cfg(VEC_CFG[0]);
    next_edge(VEC_CFG[0][4], h);
    chk("R9 first edge from idle is a rise", int'(clk_out), 1);
    next_edge(VEC_CFG[0][4], h);
    chk("R7 high phase vec0", h, VEC_HALF[0]);

    // Table walk: write just after a rise, old high phase must complete
    for (int i = 1; i < NV; i++) begin
      next_edge(VEC_CFG[i-1][4], h);
      chk("R7 low phase old setting", h, VEC_HALF[i-1]);
      write_cfg(VEC_CFG[i]);
      next_edge(VEC_CFG[i-1][4], h);
      chk("R8 high phase keeps old setting", h, VEC_HALF[i-1]);
      next_edge(VEC_CFG[i][4], h);
      chk("R4 R5 R6 low phase new setting", h, VEC_HALF[i]);
      next_edge(VEC_CFG[i][4], h);
      chk("R3 R7 high phase new setting", h, VEC_HALF[i]);
    end

    // R9: disable mid-high; full final phase, then silence
    next_edge(1'b0, h);
    chk("R7 low phase before disable", h, 128);
    write_cfg(8'h0E);
    next_edge(1'b0, h);
    chk("R9 final high phase full length", h, 128);
    e0 = edges;
    cyc_wait(3000);
    chk("R9 no edges after disable", edges - e0, 0);
    chk("R9 output low after disable", int'(clk_out), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule